// File: doc/BRIEF.md
# Four-Lane Interleaved Streaming ALU

This block keeps the throughput of a single 16-bit ALU, one operation per fast clock cycle, while giving each copy of the arithmetic logic four fast cycles to settle. A shared input register captures an operation on every fast cycle. A two-bit phase counter then hands each captured operation to one of four lane registers in round-robin order. Every lane feeds its own copy of the combinational ALU. A four-way multiplexer, steered by the same counter, takes the lane whose result has had a full four-cycle window and passes it to an output register that also runs at the full rate.

The lanes are not fed from derived clocks. Each lane register runs on the main clock and loads only when the counter selects it. Operations go in with no valid signal and come out in the same order, with a fixed latency. The flags travel with the result through the same multiplexer. The lane count and data width are parameters. The default build has four lanes and 16-bit operands.

Top module: `alu4_interleave`

## Requirements
- R1: The block accepts one operation on every clock cycle and produces one result on every clock cycle. Results leave in the order in which the operations entered.
- R2: An operation sampled at the ports on rising edge n appears on the outputs just after rising edge n+5, with the default of four lanes.
- R3: The phase counter starts at 0 after reset and steps 0,1,2,3,0,... on every edge. Exactly one lane enable is active at a time, and lane k loads only while the counter equals k. Every other lane holds its contents.
- R4: The output register samples the lane that was loaded four edges earlier. This gives each lane's logic four full cycles before its result is taken.
- R5: Opcode 4'h0 adds: result = a + b + carry-in, modulo 2^16. The carry flag is the carry out of bit 15.
- R6: Opcode 4'h1 subtracts: result = a - b - carry-in, modulo 2^16. The carry flag is 1 exactly when a < b + carry-in, treating both as unsigned values (a borrow).
- R7: Opcode 4'h2 sets the compare flag when a == b. Opcode 4'h3 sets the compare flag when a != b. Both give a result of 0 and a carry of 0.
- R8: Opcodes 4'h4 (xor), 4'h5 (nor), 4'h6 (or), 4'h7 (and) and 4'hA (nand) apply that bitwise function to a and b. Their carry and compare flags are 0.
- R9: Opcode 4'h8 passes a to the result, and opcode 4'h9 passes b to the result. Their carry and compare flags are 0.
- R10: For every defined opcode (4'h0 to 4'hA), the zero flag is 1 exactly when the result is 0.
- R11: Opcodes 4'hB to 4'hF drive the result and all three flags to 0, whatever the operands are.
- R12: A synchronous reset clears the counter, the input register, the lanes and the output register. All outputs stay 0 until the first operation accepted after reset reaches them, including the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 16 | Operand a |
| in_b | input | 16 | Operand b |
| in_op | input | 4 | Opcode |
| in_cin | input | 1 | Carry-in / borrow-in |
| out_res | output | 16 | Result |
| out_carry | output | 1 | Carry or borrow flag |
| out_zero | output | 1 | Zero flag |
| out_cmp | output | 1 | Compare flag |

## Verification
The assertions assume that reset is held for at least one edge before any check is trusted. They also assume that the inputs carry a defined opcode value on every edge, because the block has no valid signal and every cycle counts as an operation. The bench meets both assumptions: it drives every operand and opcode bit on every cycle from the falling edge, and it holds reset across several edges at start-up and again while operations are still in flight. The stimulus mixes directed corner operands (wrap-around sums, borrows, equal and unequal compares, undefined opcodes with nonzero operands) with pseudo-random operations across all sixteen opcode values.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OPC_ADD   = 4'h0;
    localparam logic [OPW-1:0] OPC_SUB   = 4'h1;
    localparam logic [OPW-1:0] OPC_EQ    = 4'h2;
    localparam logic [OPW-1:0] OPC_NE    = 4'h3;
    localparam logic [OPW-1:0] OPC_XOR   = 4'h4;
    localparam logic [OPW-1:0] OPC_NOR   = 4'h5;
    localparam logic [OPW-1:0] OPC_OR    = 4'h6;
    localparam logic [OPW-1:0] OPC_AND   = 4'h7;
    localparam logic [OPW-1:0] OPC_PASSA = 4'h8;
    localparam logic [OPW-1:0] OPC_PASSB = 4'h9;
    localparam logic [OPW-1:0] OPC_NAND  = 4'hA;
    // opcode loaded by reset: undefined, so an empty lane yields all zeros
    localparam logic [OPW-1:0] OPC_IDLE  = 4'hF;

    function automatic logic op_defined(input logic [OPW-1:0] op);
        return op <= OPC_NAND;
    endfunction

endpackage

// File: rtl/alu4_core.sv
module alu4_core #(
    parameter int W = 16
) (
    input  logic [W-1:0]              a,
    input  logic [W-1:0]              b,
    input  logic [alu4_pkg::OPW-1:0]  op,
    input  logic                      cin,
    output logic [W-1:0]              res,
    output logic                      cy,
    output logic                      zf,
    output logic                      cmp
);
    import alu4_pkg::*;

    logic [W:0] wide;

    always_comb begin
        res  = '0;
        cy   = 1'b0;
        cmp  = 1'b0;
        wide = '0;
        unique case (op)
            OPC_ADD: begin
                wide = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            OPC_SUB: begin
                wide = {1'b0, a} - {1'b0, b} - (W+1)'(cin);
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            OPC_EQ:    cmp = (a == b);
            OPC_NE:    cmp = (a != b);
            OPC_XOR:   res = a ^ b;
            OPC_NOR:   res = ~(a | b);
            OPC_OR:    res = a | b;
            OPC_AND:   res = a & b;
            OPC_PASSA: res = a;
            OPC_PASSB: res = b;
            OPC_NAND:  res = ~(a & b);
            default: begin
                res = '0;
            end
        endcase
        zf = op_defined(op) && (res == '0);
    end

endmodule

// File: rtl/alu4_phase.sv
module alu4_phase #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [$clog2(N)-1:0] phase,
    output logic [N-1:0]         lane_en
);
    localparam int PW = $clog2(N);

    typedef struct packed {
        logic [PW-1:0] ph;
    } phase_state_t;

    phase_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PW'(N-1)) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_en
        assign lane_en[k] = (st_q.ph == PW'(k));
    end

    assign phase = st_q.ph;

endmodule

// File: rtl/alu4_lane.sv
module alu4_lane #(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [2*W+alu4_pkg::OPW:0] word_in,
    output logic [W+2:0]             res_out
);
    import alu4_pkg::*;

    typedef struct packed {
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [OPW-1:0] op;
        logic           cin;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic [W-1:0] c_res;
    logic         c_cy;
    logic         c_zf;
    logic         c_cmp;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = lane_state_t'(word_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.a   <= '0;
            st_q.b   <= '0;
            st_q.op  <= OPC_IDLE;
            st_q.cin <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    alu4_core #(.W(W)) i_core (
        .a   (st_q.a),
        .b   (st_q.b),
        .op  (st_q.op),
        .cin (st_q.cin),
        .res (c_res),
        .cy  (c_cy),
        .zf  (c_zf),
        .cmp (c_cmp)
    );

    assign res_out = {c_cmp, c_zf, c_cy, c_res};

endmodule

// File: rtl/alu4_outsel.sv
module alu4_outsel #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(N)-1:0]      sel,
    input  logic [N-1:0][W+2:0]       lane_res,
    output logic [W+2:0]              out_word
);
    localparam int RW = W + 3;

    typedef struct packed {
        logic [RW-1:0] word;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = lane_res[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word = st_q.word;

endmodule

// File: rtl/alu4_interleave.sv
module alu4_interleave #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              in_a,
    input  logic [W-1:0]              in_b,
    input  logic [alu4_pkg::OPW-1:0]  in_op,
    input  logic                      in_cin,
    output logic [W-1:0]              out_res,
    output logic                      out_carry,
    output logic                      out_zero,
    output logic                      out_cmp
);
    import alu4_pkg::*;

    localparam int PW = $clog2(N);
    localparam int RW = W + 3;

    typedef struct packed {
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [OPW-1:0] op;
        logic           cin;
    } in_state_t;

    in_state_t st_d, st_q;

    logic [PW-1:0]         phase_w;
    logic [N-1:0]          lane_en_w;
    logic [N-1:0][RW-1:0]  lane_res_w;
    logic [RW-1:0]         out_word_w;

    always_comb begin
        st_d     = st_q;
        st_d.a   = in_a;
        st_d.b   = in_b;
        st_d.op  = in_op;
        st_d.cin = in_cin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.a   <= '0;
            st_q.b   <= '0;
            st_q.op  <= OPC_IDLE;
            st_q.cin <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    alu4_phase #(.N(N)) i_phase (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase_w),
        .lane_en (lane_en_w)
    );

    for (genvar k = 0; k < N; k++) begin : g_lane
        alu4_lane #(.W(W)) i_lane (
            .clk     (clk),
            .rst     (rst),
            .load    (lane_en_w[k]),
            .word_in (st_q),
            .res_out (lane_res_w[k])
        );
    end

    // the lane about to be reloaded is the one loaded N edges ago
    alu4_outsel #(.W(W), .N(N)) i_outsel (
        .clk      (clk),
        .rst      (rst),
        .sel      (phase_w),
        .lane_res (lane_res_w),
        .out_word (out_word_w)
    );

    assign out_res   = out_word_w[W-1:0];
    assign out_carry = out_word_w[W];
    assign out_zero  = out_word_w[W+1];
    assign out_cmp   = out_word_w[W+2];

endmodule

// File: rtl/alu4_interleave_chk.sv
module alu4_interleave_chk #(
    parameter int W = 16,
    parameter int N = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [$clog2(N)-1:0]      phase,
    input logic [N-1:0]              lane_en,
    input logic [N-1:0][W+2:0]       lane_res,
    input logic [alu4_pkg::OPW-1:0]  in_op,
    input logic [W-1:0]              out_res,
    input logic                      out_carry,
    input logic                      out_zero,
    input logic                      out_cmp
);
    import alu4_pkg::*;

    localparam int DL = N + 2;

    logic [OPW-1:0] dop [DL];
    logic [DL-1:0]  dv;
    logic [OPW-1:0] op_out;
    logic           op_out_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            dv <= '0;
            for (int i = 0; i < DL; i++) begin
                dop[i] <= OPC_IDLE;
            end
        end else begin
            dv     <= {dv[DL-2:0], 1'b1};
            dop[0] <= in_op;
            for (int i = 1; i < DL; i++) begin
                dop[i] <= dop[i-1];
            end
        end
    end

    assign op_out   = dop[DL-1];
    assign op_out_v = dv[DL-1];

    AST_ONE_LANE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $countones(lane_en) == 1); // R3

    AST_PHASE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(phase) == (int'($past(phase)) + 1) % N)); // R3

    for (genvar k = 0; k < N; k++) begin : g_hold
        AST_LANE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(lane_en[k])) |-> $stable(lane_res[k])); // R3
    end

    AST_ZERO_FLAG_IMPLIES_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_zero |-> (out_res == '0)); // R10

    AST_FILL_OUTPUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !op_out_v |-> (out_res == '0 && !out_carry && !out_zero && !out_cmp)); // R12

    AST_UNDEFINED_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_out_v && !op_defined(op_out))
        |-> (out_res == '0 && !out_carry && !out_zero && !out_cmp)); // R11

    AST_BITWISE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_out_v && op_out >= OPC_XOR && op_out <= OPC_NAND)
        |-> (!out_carry && !out_cmp)); // R8

    AST_COMPARE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op_out_v && (op_out == OPC_EQ || op_out == OPC_NE))
        |-> (out_res == '0 && !out_carry)); // R7

endmodule

bind alu4_interleave alu4_interleave_chk #(.W(W), .N(N)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase_w),
    .lane_en   (lane_en_w),
    .lane_res  (lane_res_w),
    .in_op     (in_op),
    .out_res   (out_res),
    .out_carry (out_carry),
    .out_zero  (out_zero),
    .out_cmp   (out_cmp)
);

// File: tb/test_alu4_interleave.sv
module test_alu4_interleave;

    localparam int W    = 16;
    localparam int N    = 4;
    localparam int FILL = N + 2;  // outputs checked before the first result: R12

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic [3:0]    in_op = 4'h0;
    logic          in_cin = 1'b0;
    logic [W-1:0]  out_res;
    logic          out_carry;
    logic          out_zero;
    logic          out_cmp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W+2:0] exp_q [$];
    int           tag_q [$];

    always #2.5 clk = ~clk;

    alu4_interleave #(.W(W), .N(N)) i_alu4_interleave (
        .clk       (clk),
        .rst       (rst),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_op     (in_op),
        .in_cin    (in_cin),
        .out_res   (out_res),
        .out_carry (out_carry),
        .out_zero  (out_zero),
        .out_cmp   (out_cmp)
    );

    // behavioural model: returns {cmp, zero, carry, result}
    function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [3:0] op, input logic cin);
        longint ua = a;
        longint ub = b;
        longint ci = cin;
        longint r  = 0;
        bit     c  = 0;
        bit     q  = 0;
        bit     ok = 1;
        case (op)
            4'h0: begin r = ua + ub + ci; c = (r >= 65536); end
            4'h1: begin c = (ua < ub + ci); r = ua - ub - ci; end
            4'h2: q = (a == b);
            4'h3: q = (a != b);
            4'h4: r = a ^ b;
            4'h5: r = ~(a | b);
            4'h6: r = a | b;
            4'h7: r = a & b;
            4'h8: r = a;
            4'h9: r = b;
            4'hA: r = ~(a & b);
            default: ok = 0;
        endcase
        r = r & 64'hFFFF;
        return {q, (ok && r == 0), c, W'(r)};
    endfunction

    function automatic string tag_of(input int op);
        if (op < 0)                     return "R12";
        if (op == 0)                    return "R5";
        if (op == 1)                    return "R6";
        if (op == 2 || op == 3)         return "R7";
        if ((op >= 4 && op <= 7) || op == 10) return "R8";
        if (op == 8 || op == 9)         return "R9";
        return "R11";
    endfunction

    // at a falling edge: check the oldest expectation, then present a new operation
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [3:0] op, input logic cin);
        logic [W+2:0] got;
        logic [W+2:0] exp;
        int           t;
        got = {out_cmp, out_zero, out_carry, out_res};
        exp = exp_q.pop_front();
        t   = tag_q.pop_front();
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (order R1, latency R2 R4, zero flag R10): got %h expected %h",
                     tag_of(t), got, exp);
        end
        in_a = a; in_b = b; in_op = op; in_cin = cin;
        exp_q.push_back(model(a, b, op, cin));
        tag_q.push_back(int'(op));
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        tag_q.delete();
        for (int i = 0; i < FILL; i++) begin
            exp_q.push_back('0);
            tag_q.push_back(-1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R5: wrap-around sums with and without carry-in
        step(16'hFFFF, 16'h0001, 4'h0, 1'b0);
        step(16'hFFFF, 16'h0000, 4'h0, 1'b1);
        step(16'h1234, 16'h4321, 4'h0, 1'b1);
        // R6: borrow cases
        step(16'h0000, 16'h0000, 4'h1, 1'b1);
        step(16'h0005, 16'h0005, 4'h1, 1'b0);
        step(16'h0003, 16'h0005, 4'h1, 1'b0);
        // R7: compares
        step(16'hA5A5, 16'hA5A5, 4'h2, 1'b1);
        step(16'hA5A5, 16'hA5A4, 4'h2, 1'b0);
        step(16'h0001, 16'h0001, 4'h3, 1'b0);
        step(16'h0001, 16'h0002, 4'h3, 1'b0);
        // R8, R9, R10: bitwise and pass, including zero results
        step(16'hF0F0, 16'hF0F0, 4'h4, 1'b1);
        step(16'h0000, 16'h0000, 4'h5, 1'b0);
        step(16'h00F0, 16'h0F00, 4'h6, 1'b0);
        step(16'hFF00, 16'h00FF, 4'h7, 1'b1);
        step(16'hBEEF, 16'h1111, 4'h8, 1'b0);
        step(16'hBEEF, 16'h0000, 4'h9, 1'b0);
        step(16'hFFFF, 16'hFFFF, 4'hA, 1'b0);
        // R11: undefined opcodes with busy operands
        for (int k = 11; k < 16; k++) begin
            step(16'hFFFF, 16'h8001, 4'(k), 1'b1);
        end
        // R1, R3: pseudo-random stream across all opcodes
        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), W'($urandom), 4'($urandom), 1'($urandom));
        end
        // R12: reset with operations in flight, then resume
        do_reset();
        for (int i = 0; i < 200; i++) begin
            step(W'($urandom), W'($urandom), 4'($urandom_range(0, 10)), 1'($urandom));
        end
        finish_run();
    end

endmodule